// File: doc/BRIEF.md
# Peripheral Address Slot Decoder

This block sits behind a 64 MB peripheral window and turns the 26-bit offset of each valid access into a module-enable strobe. The bottom 0.5 MB of the window holds 32 fine slots of 16 KB each, and each slot has its own enable. The next 0.5 MB is a hole. The remaining 63 MB is split into two equal coarse ranges, and each range has one global enable. A summary strobe marks any access that lands in one of the fine slots.

All outputs are registered. They show the decode of the access that was presented on the previous clock edge. When no access is valid, every strobe drops to zero. An access that lands in the hole raises an unmapped flag instead of an enable, so the surrounding bus logic can answer it with an error.

Top module: `periph_slot_decoder`

## Requirements
- R1: While the reset is asserted, and on the first edges after it is released, every output is low.
- R2: When acc_valid_i is low on a clock edge, every output is low after that edge.
- R3: A valid offset below 0x0080000 raises only slot_en_o[n], where n = offset[18:14].
- R4: Offset bits [13:0] have no effect on which fine slot is selected.
- R5: slot_any_o is high exactly when one of the slot_en_o bits is high.
- R6: A valid offset in 0x0080000..0x00FFFFF raises unmapped_o and no enable.
- R7: A valid offset in 0x0100000..0x207FFFF raises only glob_en_o[0].
- R8: A valid offset in 0x2080000..0x3FFFFFF raises only glob_en_o[1].
- R9: At most one of slot_en_o, glob_en_o and unmapped_o is active in any cycle.
- R10: Outputs change on the clock edge after the access is presented and hold their value between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid_i | input | 1 | An access is presented this cycle |
| acc_addr_i | input | 26 | Byte offset within the window |
| slot_en_o | output | 32 | One enable per fine 16 KB slot |
| glob_en_o | output | 2 | Enables for the lower and upper coarse ranges |
| slot_any_o | output | 1 | High when any fine slot enable is high |
| unmapped_o | output | 1 | The access fell in the hole between the fine and coarse regions |

## Verification
The hardest cases to reach are the region edges. These are the last byte of slot 31 against the first byte of the hole, the last byte of the hole against the first coarse byte, and the split point between the two global ranges. An off-by-one in a bound only shows at exactly these offsets. The stimulus table places a vector on each side of every edge. It also uses offsets whose low 14 bits are all ones, to show that those bits do not move the slot choice. Back-to-back valid cycles, and a valid followed by an idle cycle, confirm that each output tracks only the previous edge.

// File: rtl/pasd_pkg.sv
package pasd_pkg;
  // Which part of the window an offset falls into
  typedef enum logic [1:0] {
    RGN_FINE   = 2'd0,
    RGN_HOLE   = 2'd1,
    RGN_COARSE = 2'd2,
    RGN_NONE   = 2'd3
  } region_e;
endpackage

// File: rtl/pasd_rst_sync.sv
module pasd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/pasd_region_classify.sv
module pasd_region_classify
  import pasd_pkg::*;
#(
  parameter int ADDR_W    = 26,
  parameter int SLOT_LOG2 = 14,
  parameter int NUM_SLOTS = 32,
  parameter int NUM_GLOB  = 2
) (
  input  logic [ADDR_W-1:0]   addr_i,
  output region_e             region_o,
  output logic [NUM_GLOB-1:0] glob_hit_o
);
  localparam int unsigned FINE_TOP    = NUM_SLOTS * (2 ** SLOT_LOG2);
  localparam int unsigned COARSE_BASE = 2 * FINE_TOP;
  localparam int unsigned WINDOW_SZ   = 2 ** ADDR_W;
  localparam int unsigned GLOB_SPAN   = (WINDOW_SZ - COARSE_BASE) / NUM_GLOB;

  logic [31:0] addr_ext;
  assign addr_ext = 32'(addr_i);

  always_comb begin
    if (addr_ext < FINE_TOP)         region_o = RGN_FINE;
    else if (addr_ext < COARSE_BASE) region_o = RGN_HOLE;
    else                             region_o = RGN_COARSE;
  end

  for (genvar g = 0; g < NUM_GLOB; g++) begin : g_glob
    localparam int unsigned LO = COARSE_BASE + g * GLOB_SPAN;
    localparam int unsigned HI = (g == NUM_GLOB - 1) ? WINDOW_SZ : LO + GLOB_SPAN;
    assign glob_hit_o[g] = (addr_ext >= LO) && (addr_ext < HI);
  end

  // R9: at most one coarse range may claim an offset
  always_comb begin
    p_glob_excl_r9: assert ($onehot0(glob_hit_o));
  end
endmodule

// File: rtl/pasd_slot_decode.sv
module pasd_slot_decode
  import pasd_pkg::*;
#(
  parameter int NUM_SLOTS = 32,
  localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
  input  region_e              region_i,
  input  logic [IDX_W-1:0]     slot_idx_i,
  output logic [NUM_SLOTS-1:0] slot_hit_o
);
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    assign slot_hit_o[s] = (region_i == RGN_FINE) && (slot_idx_i == IDX_W'(s));
  end

  // R3: a fine-region offset picks exactly one slot
  always_comb begin
    if (region_i == RGN_FINE) p_slot_onehot_r3: assert ($onehot(slot_hit_o));
    else                      p_slot_quiet_r3:  assert (slot_hit_o == '0);
  end
endmodule

// File: rtl/pasd_out_regs.sv
module pasd_out_regs
  import pasd_pkg::*;
#(
  parameter int NUM_SLOTS = 32,
  parameter int NUM_GLOB  = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 valid_i,
  input  region_e              region_i,
  input  logic [NUM_SLOTS-1:0] slot_hit_i,
  input  logic [NUM_GLOB-1:0]  glob_hit_i,
  output logic [NUM_SLOTS-1:0] slot_en_q,
  output logic [NUM_GLOB-1:0]  glob_en_q,
  output logic                 slot_any_q,
  output logic                 unmapped_q
);
  logic [NUM_SLOTS-1:0] slot_en_d;
  logic [NUM_GLOB-1:0]  glob_en_d;
  logic                 slot_any_d;
  logic                 unmapped_d;
  logic                 busy_q;
  logic                 upd_en;

  // Next-state
  always_comb begin
    slot_en_d  = '0;
    glob_en_d  = '0;
    unmapped_d = 1'b0;
    if (valid_i) begin
      unique case (region_i)
        RGN_FINE:   slot_en_d  = slot_hit_i;
        RGN_HOLE:   unmapped_d = 1'b1;
        RGN_COARSE: glob_en_d  = glob_hit_i;
        default:    ;
      endcase
    end
    slot_any_d = |slot_en_d;
  end

  assign busy_q = (|slot_en_q) | (|glob_en_q) | unmapped_q;
  assign upd_en = valid_i | busy_q;

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_en_q  <= '0;
      glob_en_q  <= '0;
      slot_any_q <= 1'b0;
      unmapped_q <= 1'b0;
    end else if (upd_en) begin
      slot_en_q  <= slot_en_d;
      glob_en_q  <= glob_en_d;
      slot_any_q <= slot_any_d;
      unmapped_q <= unmapped_d;
    end
  end

  // R2: an idle edge clears every strobe
  p_idle_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> (slot_en_q == '0) && (glob_en_q == '0) && !unmapped_q && !slot_any_q);

  // R5: summary tracks the fine enables
  p_summary_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
    slot_any_q |-> $onehot(slot_en_q));
  p_summary_lo_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_any_q |-> (slot_en_q == '0));

  // R6: a hole access flags unmapped and nothing else
  p_hole_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && region_i == RGN_HOLE) |=> unmapped_q && (slot_en_q == '0) && (glob_en_q == '0));

  // R9: one destination at most
  p_one_dest_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({slot_en_q, glob_en_q, unmapped_q}));

  // R10: outputs follow the previous edge's fine decode
  p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && region_i == RGN_FINE) |=> (slot_en_q == $past(slot_hit_i)));
endmodule

// File: rtl/periph_slot_decoder.sv
module periph_slot_decoder
  import pasd_pkg::*;
#(
  parameter int ADDR_W    = 26,
  parameter int SLOT_LOG2 = 14,
  parameter int NUM_SLOTS = 32,
  parameter int NUM_GLOB  = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 acc_valid_i,
  input  logic [ADDR_W-1:0]    acc_addr_i,
  output logic [NUM_SLOTS-1:0] slot_en_o,
  output logic [NUM_GLOB-1:0]  glob_en_o,
  output logic                 slot_any_o,
  output logic                 unmapped_o
);
  localparam int IDX_W = $clog2(NUM_SLOTS);

  logic                 rst_sync_n;
  region_e              region;
  logic [NUM_GLOB-1:0]  glob_hit;
  logic [NUM_SLOTS-1:0] slot_hit;

  pasd_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pasd_region_classify #(
    .ADDR_W(ADDR_W), .SLOT_LOG2(SLOT_LOG2), .NUM_SLOTS(NUM_SLOTS), .NUM_GLOB(NUM_GLOB)
  ) u_cls (
    .addr_i     (acc_addr_i),
    .region_o   (region),
    .glob_hit_o (glob_hit)
  );

  pasd_slot_decode #(.NUM_SLOTS(NUM_SLOTS)) u_slot (
    .region_i   (region),
    .slot_idx_i (acc_addr_i[SLOT_LOG2 +: IDX_W]),
    .slot_hit_o (slot_hit)
  );

  pasd_out_regs #(.NUM_SLOTS(NUM_SLOTS), .NUM_GLOB(NUM_GLOB)) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .valid_i    (acc_valid_i),
    .region_i   (region),
    .slot_hit_i (slot_hit),
    .glob_hit_i (glob_hit),
    .slot_en_q  (slot_en_o),
    .glob_en_q  (glob_en_o),
    .slot_any_q (slot_any_o),
    .unmapped_q (unmapped_o)
  );
endmodule

// File: tb/periph_slot_decoder_tb.sv
`timescale 1ns/1ps
module periph_slot_decoder_tb_top;
  // Expected codes: 0..31 slot n, 32 glob 0, 33 glob 1, 40 unmapped, 63 all low
  localparam int NV = 16;
  localparam logic [34:0] VEC [NV] = '{
    {1'b1, 26'h0000000, 8'd0},   // R3 first slot
    {1'b1, 26'h0003FFF, 8'd0},   // R4 low bits all ones
    {1'b1, 26'h0004000, 8'd1},   // R3
    {1'b1, 26'h0048ABC, 8'd18},  // R4 mixed low bits
    {1'b1, 26'h0028000, 8'd10},  // R3
    {1'b1, 26'h007C000, 8'd31},  // R3 last slot
    {1'b1, 26'h007FFFF, 8'd31},  // R4 top of fine region
    {1'b1, 26'h0080000, 8'd40},  // R6 hole start
    {1'b1, 26'h00FFFFF, 8'd40},  // R6 hole end
    {1'b1, 26'h0100000, 8'd32},  // R7 coarse start
    {1'b1, 26'h1234567, 8'd32},  // R7
    {1'b1, 26'h207FFFF, 8'd32},  // R7 last byte of lower range
    {1'b1, 26'h2080000, 8'd33},  // R8 split point
    {1'b1, 26'h3FFFFFF, 8'd33},  // R8 top of window
    {1'b0, 26'h0004000, 8'd63},  // R2 idle slot offset
    {1'b0, 26'h0080000, 8'd63}   // R2 idle hole offset
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_valid_i;
  logic [25:0] acc_addr_i;
  logic [31:0] slot_en_o;
  logic [1:0]  glob_en_o;
  logic        slot_any_o;
  logic        unmapped_o;
  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  periph_slot_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .acc_valid_i(acc_valid_i), .acc_addr_i(acc_addr_i),
    .slot_en_o(slot_en_o), .glob_en_o(glob_en_o), .slot_any_o(slot_any_o),
    .unmapped_o(unmapped_o)
  );

  task automatic check(input int code, input string req);
    logic [31:0] es = '0;
    logic [1:0]  eg = '0;
    logic        eu = 1'b0;
    if (code < 32) es[code] = 1'b1;
    else if (code == 32) eg = 2'b01;
    else if (code == 33) eg = 2'b10;
    else if (code == 40) eu = 1'b1;
    n_chk++;
    if (slot_en_o !== es || glob_en_o !== eg || unmapped_o !== eu || slot_any_o !== (|es)) begin
      n_fail++;
      $display("FAIL %s: got slot=%h glob=%b any=%b unm=%b, expected slot=%h glob=%b any=%b unm=%b",
               req, slot_en_o, glob_en_o, slot_any_o, unmapped_o, es, eg, |es, eu);
    end
  endtask

  task automatic apply(input logic v, input logic [25:0] a);
    @(negedge clk);
    acc_valid_i = v;
    acc_addr_i  = a;
  endtask

  initial begin
    #4000000;
    n_fail++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    acc_valid_i = 1'b1;
    acc_addr_i = 26'h0004000;
    repeat (3) @(posedge clk);
    #1 check(63, "R1 during reset");
    @(negedge clk) rst_n = 1'b1;
    acc_valid_i = 1'b0;
    repeat (4) @(negedge clk);
    check(63, "R1 after release");

    // Vector table: each vector is checked one edge after it is driven
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][34], VEC[i][33:8]);
      @(negedge clk);
      check(int'(VEC[i][7:0]), $sformatf("R3-R8 vector %0d", i));
    end

    // R10: back-to-back valid cycles, and the value before the edge is held
    apply(1'b1, 26'h0014000);            // slot 5
    @(posedge clk); #1;
    apply(1'b1, 26'h2100000);            // glob 1, driven at negedge
    #1 check(5, "R10 hold before edge");
    @(posedge clk); #1 check(33, "R10 next edge");

    // R2: valid then idle clears on the next edge
    apply(1'b0, 26'h2100000);
    @(negedge clk) check(63, "R2 idle after valid");

    // R9/R5: hole then slot back to back
    apply(1'b1, 26'h00C0000);
    @(negedge clk) check(40, "R9 hole");
    acc_addr_i = 26'h0078001;            // slot 30
    @(negedge clk) check(30, "R5 summary after hole");

    // R1: asynchronous reset mid-run clears at once
    #2 rst_n = 1'b0;
    #1 check(63, "R1 async clear");
    @(negedge clk) rst_n = 1'b1;
    acc_valid_i = 1'b0;
    repeat (3) @(negedge clk);
    check(63, "R1 after second release");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule